// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs sequences of analog-to-digital conversions for a converter that sits behind an 8-way input multiplexer. Software sets up power, sequence length, result format and a start channel through a small register port. Writing the start register launches a sequence. For each conversion the controller raises a request toward the converter, together with a channel number. When the converter answers with a done pulse and a 10-bit code, the controller stores the code in the next result slot.

A sequence uses either one channel or several. In single-channel mode every conversion uses the start channel. In multi-channel mode the channel steps up by one per conversion and wraps after 7. A sequence either stops after its last conversion or restarts at slot 0 and keeps overwriting. Each slot has a complete flag. A status word holds a sequence-done flag, an overrun flag, a busy bit and the index of the next slot. A write to any setup register cancels the running sequence. The result is shifted and sign-adjusted when it is read.

Top module: `adc_seq_ctrl`

Register map (word addresses):
- 0: config. Bit 0 is power enable, bit 1 is interrupt enable.
- 1: length, in bits [3:0].
- 2: format. Bit 0 selects left justification, bit 1 selects signed.
- 3: start. Channel in [2:0], multi-channel in bit 8, continuous scan in bit 9.
- 4: status.
- 5: complete flags.
- 8 to 15: result slots 0 to 7.

## Requirements
- R1: After reset, conv_req_o and irq_o are 0, and status (address 4) and the flag word (address 5) both read 0.
- R2: In single-channel mode (start bit 8 = 0) every conversion of a sequence uses the start channel.
- R3: In multi-channel mode (start bit 8 = 1), conversion k uses channel (start + k) mod 8 and stores into slot k.
- R4: The length field gives 1 to 8 conversions per sequence. The value 0 (or any value above 8) gives 8.
- R5: Without scan (start bit 9 = 0), the block stops after the last conversion of the sequence. It then sets the done flag (status bit 0), clears busy (status bit 2) and returns the slot counter (status bits [10:8]) to 0.
- R6: With scan (start bit 9 = 1), the block sets done at the end of each pass and restarts at slot 0. Storing into a slot whose complete flag is still set raises overrun (status bit 1).
- R7: Storing into slot k sets bit k of the flag word. Reading result address 8+k clears that bit.
- R8: A write to address 0, 1 or 2 stops a running sequence: the request drops on the next cycle and the slot counter returns to 0. Stored results and flags are kept.
- R9: A write to address 3 restarts the sequence from slot 0, but only when power (config bit 0) is 1. With power 0 no request is ever raised.
- R10: irq_o is the done flag gated by config bit 1. Writing 1 to status bit 0 or bit 1 clears that flag.
- R11: Result reads are formatted by format bit 0 and bit 1. Unsigned right justification zero-extends the code. Left justification places the code in bits [15:6]. Signed inverts the code MSB and, when right-justified, sign-extends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_ch_o | output | 3 | Multiplexer channel for the current request |
| conv_done_i | input | 1 | Converter result strobe |
| conv_code_i | input | 10 | Converter result code |
| irq_o | output | 1 | Sequence-done interrupt |

## Verification
The bench builds the block with its default parameters: 8 channels, 8 slots and a 10-bit code. These defaults make a full 8-slot sequence and the channel wrap from 7 to 0 reachable in a short run. A converter model completes requests only while expected items are queued. This lets the bench stall a sequence at a chosen slot and then abort it, or let a scan pass overwrite unread slots and raise overrun. Codes with the MSB set on channels 4 to 7 exercise sign handling in every format mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEQ   = 4'd1;
  localparam logic [ADDR_W-1:0] A_FMT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_START = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'd5;
  localparam logic [ADDR_W-1:0] A_RES   = 4'd8;
  localparam int START_MULTI_BIT = 8;
  localparam int START_SCAN_BIT  = 9;
  localparam int STAT_CNT_LSB    = 8;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MAX_LEN = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int LEN_W = $clog2(MAX_LEN) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              power_o,
  output logic              irq_en_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              left_o,
  output logic              sgn_o,
  output logic [CH_W-1:0]   start_ch_o,
  output logic              multi_o,
  output logic              scan_o,
  output logic              abort_o,
  output logic              start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      power_o    <= 1'b0;
      irq_en_o   <= 1'b0;
      len_o      <= '0;
      left_o     <= 1'b0;
      sgn_o      <= 1'b0;
      start_ch_o <= '0;
      multi_o    <= 1'b0;
      scan_o     <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CFG: begin
          power_o  <= wdata_i[0];
          irq_en_o <= wdata_i[1];
        end
        A_SEQ: len_o <= wdata_i[LEN_W-1:0];
        A_FMT: begin
          left_o <= wdata_i[0];
          sgn_o  <= wdata_i[1];
        end
        A_START: begin
          start_ch_o <= wdata_i[CH_W-1:0];
          multi_o    <= wdata_i[START_MULTI_BIT];
          scan_o     <= wdata_i[START_SCAN_BIT];
        end
        default: ;
      endcase
    end
  end

  // any setup write cancels; start write relaunches when powered
  assign abort_o = wr_en_i && (addr_i <= A_START);
  assign start_o = wr_en_i && (addr_i == A_START) && power_o;
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine #(
  parameter int NUM_CH = 8,
  parameter int MAX_LEN = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int SLOT_W = $clog2(MAX_LEN),
  localparam int LEN_W = SLOT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic [CH_W-1:0]   start_ch_i,
  input  logic              multi_i,
  input  logic              scan_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              conv_done_i,
  output logic              busy_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              store_o,
  output logic              seq_end_o
);
  logic [SLOT_W-1:0] idx_q, last_idx;
  logic              busy_q;

  always_comb begin
    if (len_i == '0 || len_i > LEN_W'(MAX_LEN)) last_idx = SLOT_W'(MAX_LEN - 1);
    else                                        last_idx = SLOT_W'(len_i - 1'b1);
  end

  assign ch_o      = multi_i ? CH_W'((32'(start_ch_i) + 32'(idx_q)) % NUM_CH) : start_ch_i;
  assign store_o   = busy_q && conv_done_i && !abort_i;
  assign seq_end_o = store_o && (idx_q == last_idx);
  assign busy_o    = busy_q;
  assign slot_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (abort_i) begin
      busy_q <= start_i;
      idx_q  <= '0;
    end else if (store_o) begin
      if (idx_q == last_idx) begin
        idx_q  <= '0;
        busy_q <= scan_i;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int MAX_LEN = 8,
  parameter int RES_W = 10,
  parameter int DATA_W = 16,
  localparam int SLOT_W = $clog2(MAX_LEN),
  localparam int PAD = DATA_W - RES_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [RES_W-1:0]  code_i,
  input  logic              rd_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic              left_i,
  input  logic              sgn_i,
  output logic [MAX_LEN-1:0] flags_o,
  output logic              ovr_set_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [RES_W-1:0] mem_q [MAX_LEN];
  logic [RES_W-1:0] sc;

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (store_i && slot_i == SLOT_W'(i)) mem_q[i] <= code_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                flags_o[i] <= 1'b0;
      else if (store_i && slot_i == SLOT_W'(i))   flags_o[i] <= 1'b1;
      else if (rd_i && rd_slot_i == SLOT_W'(i))   flags_o[i] <= 1'b0;
    end
  end

  // a read of the same slot in the same cycle counts as consumed
  assign ovr_set_o = store_i && flags_o[slot_i] && !(rd_i && rd_slot_i == slot_i);

  always_comb begin
    sc = mem_q[rd_slot_i];
    if (sgn_i) sc[RES_W-1] = ~sc[RES_W-1];
    if (left_i)     rdata_o = {sc, {PAD{1'b0}}};
    else if (sgn_i) rdata_o = {{PAD{sc[RES_W-1]}}, sc};
    else            rdata_o = {{PAD{1'b0}}, sc};
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MAX_LEN = 8,
  parameter int RES_W = 10,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int SLOT_W = $clog2(MAX_LEN),
  localparam int LEN_W = SLOT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_code_i,
  output logic              irq_o
);
  logic power, irq_en, left, sgn, multi, scan, abort, start;
  logic busy, store, seq_end, ovr_set, res_rd;
  logic [LEN_W-1:0]   len;
  logic [CH_W-1:0]    start_ch;
  logic [SLOT_W-1:0]  slot, rd_slot;
  logic [MAX_LEN-1:0] flags;
  logic [DATA_W-1:0]  res_data;
  logic seq_done_q, ovr_q;

  adc_seq_regs #(.NUM_CH(NUM_CH), .MAX_LEN(MAX_LEN)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .power_o(power), .irq_en_o(irq_en), .len_o(len), .left_o(left), .sgn_o(sgn),
    .start_ch_o(start_ch), .multi_o(multi), .scan_o(scan),
    .abort_o(abort), .start_o(start)
  );

  adc_seq_engine #(.NUM_CH(NUM_CH), .MAX_LEN(MAX_LEN)) u_engine (
    .clk_i, .rst_ni, .abort_i(abort), .start_i(start), .start_ch_i(start_ch),
    .multi_i(multi), .scan_i(scan), .len_i(len), .conv_done_i,
    .busy_o(busy), .ch_o(conv_ch_o), .slot_o(slot), .store_o(store), .seq_end_o(seq_end)
  );

  assign rd_slot = SLOT_W'(addr_i - A_RES);
  assign res_rd  = rd_en_i && (addr_i >= A_RES) && (32'(addr_i - A_RES) < MAX_LEN);

  adc_seq_results #(.MAX_LEN(MAX_LEN), .RES_W(RES_W), .DATA_W(DATA_W)) u_results (
    .clk_i, .rst_ni, .store_i(store), .slot_i(slot), .code_i(conv_code_i),
    .rd_i(res_rd), .rd_slot_i(rd_slot), .left_i(left), .sgn_i(sgn),
    .flags_o(flags), .ovr_set_o(ovr_set), .rdata_o(res_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_done_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (seq_end)                                          seq_done_q <= 1'b1;
      else if (wr_en_i && addr_i == A_STAT && wdata_i[0])   seq_done_q <= 1'b0;
      if (ovr_set)                                          ovr_q <= 1'b1;
      else if (wr_en_i && addr_i == A_STAT && wdata_i[1])   ovr_q <= 1'b0;
    end
  end

  assign conv_req_o = busy;
  assign irq_o      = seq_done_q && irq_en;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_STAT) begin
      rdata_o[0] = seq_done_q;
      rdata_o[1] = ovr_q;
      rdata_o[2] = busy;
      rdata_o[STAT_CNT_LSB +: SLOT_W] = slot;
    end else if (addr_i == A_FLAGS) begin
      rdata_o[MAX_LEN-1:0] = flags;
    end else if (addr_i >= A_RES) begin
      rdata_o = res_data;
    end
  end
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MAX_LEN = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       conv_req_o,
  input logic [$clog2(NUM_CH)-1:0]  conv_ch_o,
  input logic                       conv_done_i,
  input logic                       irq_o,
  input logic                       power,
  input logic                       multi,
  input logic                       seq_done_q,
  input logic [MAX_LEN-1:0]         flags
);
  p_req_needs_power_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> power);
  p_start_launch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_START && power) |=> conv_req_o);
  p_setup_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i < A_START) |=> !conv_req_o);
  p_single_channel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !multi && !wr_en_i) |=> (!conv_req_o || $stable(conv_ch_o)));
  p_done_after_conv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_done_q) |-> $past(conv_done_i && conv_req_o));
  p_flag_on_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && conv_req_o && !wr_en_i) |=> (flags != '0));
  p_irq_needs_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> seq_done_q);
endmodule

bind adc_seq_ctrl adc_seq_checker #(.NUM_CH(NUM_CH), .MAX_LEN(MAX_LEN)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .conv_req_o, .conv_ch_o, .conv_done_i,
  .irq_o, .power, .multi, .seq_done_q, .flags
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, conv_done = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata, d;
  logic conv_req, irq;
  logic [2:0] conv_ch;
  logic [9:0] conv_code = 0;

  typedef struct { int ch; int slot; } item_t;
  item_t exp_q[$];
  int exp_code[8];
  int checks = 0, errors = 0, code_seq = 0, wait_cnt = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .conv_req_o(conv_req), .conv_ch_o(conv_ch),
    .conv_done_i(conv_done), .conv_code_i(conv_code), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk); wr_en = 1; addr = a; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  // driver: queue the expected channel/slot of every conversion
  task automatic push_seq(input int ch, input bit multi, input int len, input int passes);
    for (int p = 0; p < passes; p++)
      for (int k = 0; k < len; k++) begin
        item_t it;
        it.ch = multi ? (ch + k) % 8 : ch;
        it.slot = k;
        exp_q.push_back(it);
      end
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] fmt(input int code, input bit left, input bit sgn);
    logic [9:0] v;
    v = 10'(code);
    if (sgn) v[9] = ~v[9];
    if (left) return {v, 6'b0};
    return sgn ? {{6{v[9]}}, v} : {6'b0, v};
  endfunction

  task automatic check_slots(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      rd(4'(8 + k), d);
      chk(d == fmt(exp_code[k], 0, 0), req, d, fmt(exp_code[k], 0, 0));
    end
  endtask

  // monitor + converter model: completes only queued conversions
  initial forever begin
    @(negedge clk);
    if (conv_done) conv_done = 0;
    else if (conv_req && exp_q.size() > 0) begin
      if (wait_cnt == 1) begin
        item_t it;
        it = exp_q.pop_front();
        chk(int'(conv_ch) == it.ch, "R2 R3 channel", conv_ch, it.ch);
        conv_code = 10'((int'(conv_ch) * 128 + code_seq) % 1024);
        code_seq++;
        exp_code[it.slot] = int'(conv_code);
        conv_done = 1;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(conv_req == 0, "R1 req", conv_req, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rd(4, d); chk(d == 0, "R1 status", d, 0);
    rd(5, d); chk(d == 0, "R1 flags", d, 0);

    // R2/R5 single channel one-shot
    wr(0, 16'h3);
    wr(1, 16'd4);
    push_seq(5, 0, 4, 1);
    wr(3, 16'h0005);
    wait_idle();
    rd(4, d); chk(d == 16'h0001, "R5 status after one-shot", d, 1);
    chk(irq == 1, "R10 irq raised", irq, 1);
    rd(5, d); chk(d == 16'h000F, "R7 flags set", d, 16'h0F);
    check_slots(4, "R2 results");
    rd(5, d); chk(d == 0, "R7 flags cleared by read", d, 0);

    // R10 write-one-to-clear
    wr(4, 16'h1);
    rd(4, d); chk(d == 0, "R10 done cleared", d, 0);
    chk(irq == 0, "R10 irq cleared", irq, 0);

    // R3 multi channel with wrap
    push_seq(6, 1, 4, 1);
    wr(3, 16'h0106);
    wait_idle();
    check_slots(4, "R3 results");
    wr(4, 16'h1);

    // R4 length 0 means 8
    wr(1, 16'd0);
    push_seq(0, 1, 8, 1);
    wr(3, 16'h0100);
    wait_idle();
    rd(5, d); chk(d == 16'h00FF, "R4 eight slots", d, 16'hFF);
    check_slots(8, "R4 results");
    wr(4, 16'h1);

    // R6 scan: two passes, overrun on unread slots
    wr(1, 16'd2);
    push_seq(2, 0, 2, 2);
    wr(3, 16'h0202);
    wait_idle();
    rd(4, d); chk(d == 16'h0007, "R6 scan status", d, 7);
    rd(5, d); chk(d == 16'h0003, "R6 scan flags", d, 3);
    rd(8, d); chk(d == fmt(exp_code[0], 0, 0), "R6 overwritten slot", d, fmt(exp_code[0], 0, 0));
    wr(2, 16'h0);
    chk(conv_req == 0, "R8 abort by format write", conv_req, 0);
    rd(4, d); chk(d[2] == 0, "R8 busy cleared", d[2], 0);
    wr(4, 16'h3);
    rd(9, d);

    // R8 abort mid-sequence keeps results
    wr(1, 16'd5);
    push_seq(1, 1, 2, 1);
    wr(3, 16'h0101);
    wait_idle();
    rd(4, d); chk(d == 16'h0204, "R8 stalled at slot 2", d, 16'h0204);
    wr(1, 16'd5);
    chk(conv_req == 0, "R8 request dropped", conv_req, 0);
    rd(4, d); chk(d == 0, "R8 counter reset", d, 0);
    rd(5, d); chk(d == 16'h0003, "R8 flags kept", d, 3);
    rd(8, d); rd(9, d);

    // R9 no start without power
    wr(0, 16'h2);
    wr(3, 16'h0000);
    chk(conv_req == 0, "R9 no request unpowered", conv_req, 0);
    repeat (3) @(negedge clk);
    rd(4, d); chk(d == 0, "R9 idle unpowered", d, 0);

    // R10 interrupt disabled
    wr(0, 16'h1);
    wr(1, 16'd1);
    push_seq(6, 0, 1, 1);
    wr(3, 16'h0006);
    wait_idle();
    rd(4, d); chk(d == 16'h0001, "R9 R5 powered run done", d, 1);
    chk(irq == 0, "R10 irq masked", irq, 0);

    // R11 formatting of slot 0 (code MSB set)
    for (int m = 0; m < 4; m++) begin
      wr(2, 16'(m));
      rd(8, d);
      chk(d == fmt(exp_code[0], m[0], m[1]), "R11 format", d, fmt(exp_code[0], m[0], m[1]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule